// File: doc/BRIEF.md
# Modulo 65519 Residue Adder

This block adds two residues and returns their sum reduced modulo m = 2^n − 2^k − 1. With the default n = 16 and k = 4 the modulus is 65519. Both operands must already lie in [0, m−1]. The result lies in the same range. The block is purely combinational, so the result follows the operands in the same cycle.

Two sums are formed in parallel: the plain sum A + B, and a corrected sum A + B + T, where T = 2^n − m = 2^k + 1 = 17 (0x0011). The carry out of the n-bit corrected sum is set exactly when A + B ≥ m. That carry chooses the corrected sum, truncated to n bits. When the carry is clear the plain sum is used.

Every adder is split into 4-bit groups. Each group above the lowest prepares its sum for a carry-in of 0 and for a carry-in of 1. The carry from the group below then selects one of the two.

Top module: `resid_mod_adder`

## Requirements
- R1: For any operands opA, opB in [0, 65518], result equals (opA + opB) mod 65519.
- R2: result is always strictly below 65519 while both operands are in range.
- R3: When opA + opB equals 65519 exactly, result is 0.
- R4: When opA + opB equals 65518, result is 65518, taken from the uncorrected path.
- R5: When opA + opB equals 65520, result is 1.
- R6: When opA + opB ≥ 65519, result equals opA + opB − 65519. Below that, result equals opA + opB unchanged.
- R7: Two zero operands give 0. Two operands of 65518 give 65517.
- R8: The block has no state. result reflects the present operands with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First residue operand, below the modulus |
| opB | input | 16 | Second residue operand, below the modulus |
| result | output | 16 | (opA + opB) modulo 65519 |

## Verification
The bench concentrates on sums near the modulus, where the choice between the two paths flips. Sums of m−1, m and m+1 are applied for operand A swept across the whole range.

A design that keyed the choice on the plain carry out of bit 15 would return m instead of 0 when the sum equals m. It would also produce values above m−1 for sums between m and 2^16 − 1.

A wrong correction constant shifts every wrapped result by a fixed amount. A broken group carry-select corrupts only the nibbles above a carry boundary. Random pairs and the all-ones-nibble operands expose both faults.

// File: rtl/resid_mod_pkg.sv
package resid_mod_pkg;
  localparam int unsigned DefWidth = 16;
  localparam int unsigned DefLowExp = 4;
  localparam int unsigned DefGroup = 4;

  typedef struct packed {
    logic takeWrapped;
    logic takeDirect;
  } selStrb_t;
endpackage

// File: rtl/resid_csel_add.sv
module resid_csel_add #(
  parameter int unsigned W = 16,
  parameter int unsigned G = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned NG = W / G;

  logic [NG:0] carry;
  assign carry[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : gGrp
    logic [G:0] sumLow;
    logic [G:0] sumInc;
    assign sumLow = {1'b0, a[g*G +: G]} + {1'b0, b[g*G +: G]};
    assign sumInc = sumLow + {{G{1'b0}}, 1'b1};
    assign sum[g*G +: G] = carry[g] ? sumInc[G-1:0] : sumLow[G-1:0];
    assign carry[g+1] = carry[g] ? sumInc[G] : sumLow[G];
  end

  assign cout = carry[NG];

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      // R1
      grp_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("grouped sum mismatch");
    end
  end
endmodule

// File: rtl/resid_mod_ctrl.sv
module resid_mod_ctrl
  import resid_mod_pkg::*;
(
  input  logic     wrapCarry,
  output selStrb_t strb
);
  always_comb begin
    strb.takeWrapped = wrapCarry;
    strb.takeDirect  = ~wrapCarry;
  end

  always_comb begin
    if (!$isunknown(wrapCarry)) begin
      // R6
      sel_onehot_chk: assert ($onehot(strb)) else $error("path select not one-hot");
    end
  end
endmodule

// File: rtl/resid_mod_dp.sv
module resid_mod_dp
  import resid_mod_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter int unsigned K = 4,
  parameter int unsigned G = 4
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  selStrb_t     strb,
  output logic         wrapCarry,
  output logic [N-1:0] result
);
  localparam logic [N-1:0] CorrT = N'((2 ** K) + 1);

  logic [N-1:0] plainSum;
  logic         plainCarry;
  logic [N-1:0] biasedA;
  logic         biasCarry;
  logic [N-1:0] corrSum;

  resid_csel_add #(.W(N), .G(G)) uPlain (
    .a(opA), .b(opB), .cin(1'b0), .sum(plainSum), .cout(plainCarry)
  );

  resid_csel_add #(.W(N), .G(G)) uBias (
    .a(opA), .b(CorrT), .cin(1'b0), .sum(biasedA), .cout(biasCarry)
  );

  resid_csel_add #(.W(N), .G(G)) uCorr (
    .a(biasedA), .b(opB), .cin(1'b0), .sum(corrSum), .cout(wrapCarry)
  );

  always_comb begin
    result = '0;
    if (strb.takeWrapped) result = corrSum;
    if (strb.takeDirect)  result = plainSum;
  end

  always_comb begin
    if (!$isunknown({opA, opB, strb})) begin
      // R6
      direct_nowrap_chk: assert (!(strb.takeDirect && plainCarry))
        else $error("direct path chosen although plain sum overflowed");
      // R2
      bias_noovf_chk: assert (!(opA < (N'(2 ** N - 1) - CorrT + N'(1)) && biasCarry))
        else $error("biased operand overflowed");
    end
  end
endmodule

// File: rtl/resid_mod_adder.sv
module resid_mod_adder
  import resid_mod_pkg::*;
#(
  parameter int unsigned N = DefWidth,
  parameter int unsigned K = DefLowExp,
  parameter int unsigned G = DefGroup
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] result
);
  localparam logic [N:0] Modulus = (N+1)'((2 ** N) - (2 ** K) - 1);

  selStrb_t strb;
  logic     wrapCarry;

  resid_mod_ctrl uCtrl (
    .wrapCarry(wrapCarry),
    .strb(strb)
  );

  resid_mod_dp #(.N(N), .K(K), .G(G)) uDp (
    .opA(opA), .opB(opB), .strb(strb), .wrapCarry(wrapCarry), .result(result)
  );

  always_comb begin
    if (!$isunknown({opA, opB}) && ({1'b0, opA} < Modulus) && ({1'b0, opB} < Modulus)) begin
      // R2
      in_range_chk: assert ({1'b0, result} < Modulus) else $error("result not reduced");
      // R3
      exact_mod_chk: assert (!(({1'b0, opA} + {1'b0, opB}) == Modulus) || result == '0)
        else $error("sum equal to modulus did not give zero");
    end
  end
endmodule

// File: tb/tb_resid_mod_adder.sv
`timescale 1ns/1ps
module tb_resid_mod_adder;
  localparam int M = 65519;

  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] result;
  int vecCount = 0;
  int badCount = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  resid_mod_adder dut (.opA(opA), .opB(opB), .result(result));

  task automatic apply(input int a, input int b, input string req);
    int expv;
    @(negedge clk);
    opA = 16'(a);
    opB = 16'(b);
    #2;
    expv = (a + b) % M;
    vecCount++;
    if (int'(result) != expv || int'(result) >= M) begin
      badCount++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, result, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        badCount++;
        $display("FAIL watchdog expired actual=%0d cycles expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
        $finish;
      end
    end
  end

  initial begin
    // R8: zero operands, no latency: output read 2ns after drive
    apply(0, 0, "R8");
    // R7 corners
    apply(0, 0, "R7");
    apply(M-1, M-1, "R7");
    apply(M-1, 0, "R7");
    apply(0, M-1, "R7");
    apply(16'h0FFF, 16'h0001, "R1");
    apply(16'hF0F0, 16'h0F0E, "R1");
    // boundary sweeps around the modulus
    for (int a = 0; a < M; a += 97) begin
      apply(a, M-1-a, "R4");
      if (a > 0) apply(a, M-a, "R3");
      if (a > 1) apply(a, M+1-a, "R5");
      apply(a, M-1, "R6");
      apply(a, 0, "R6");
    end
    apply(1, M-1, "R3");
    apply(2, M-1, "R5");
    // random pairs
    for (int i = 0; i < 40000; i++) begin
      int ra;
      int rb;
      ra = int'($urandom % M);
      rb = int'($urandom % M);
      apply(ra, rb, (i % 2 == 0) ? "R1" : "R2");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end
endmodule